// File: doc/BRIEF.md
# Self-Clocked Serial Output Port with Scheduled Chip-Select Polling

This block presents a parallel conversion word on a single serial data line, driving its own serial clock at one quarter of the master clock. It runs a fixed repeating frame of 1024 master clocks. At each frame boundary it captures the incoming word into a holding register and pulls the active-low ready flag low. The word itself comes from a converter outside the block.

Chip select is not watched continuously. It is examined only at eight fixed instants in each frame. When one of these checks finds chip select asserted, with enough setup time, the port shifts the held word out MSB first. It then raises the ready flag and releases both serial lines. The host drives chip select low and leaves it low until the port releases the lines. If the host deasserts chip select early, the port ends the transfer cleanly at the end of the current bit. A transfer that starts in the final window of a frame is still running when the frame boundary arrives. In that case the capture at that boundary is skipped and the next capture waits one more frame.

Top module: `sport_ssc_tx`

## Requirements
- R1: While reset is low, the ready flag is high, both output enables are low and the serial clock is low. On the first clock edge after reset is released, a frame starts: the ready flag falls and `din` is captured.
- R2: With no transfer in progress, the ready flag stays low for 1020 master clocks, is high for 4 clocks, and falls again at the next frame boundary. The boundary comes every 1024 clocks. A fresh word is captured on each fall.
- R3: Number the clock edge on which a frame starts as cycle 1. Chip select is checked only on cycles 76 + 128·k, for k = 0..7. A low chip select at any other time starts nothing.
- R4: A check succeeds only if `cs_n` was sampled low on the checking edge and on each of the 3 edges before it. With only 2 earlier low samples, that window is skipped.
- R5: On the checking edge, both output enables rise, the serial clock is low and `sdata` shows the MSB. Each bit lasts 4 clocks: 2 with the serial clock low, then 2 with it high. The next bit appears on the edge where the serial clock falls. All WORD_W bits go out MSB first.
- R6: A complete transfer lasts 4·WORD_W clocks. On its last edge, both output enables drop, the serial clock is low and the ready flag rises. This happens even if chip select is still low.
- R7: If `cs_n` is sampled high during a bit, that bit is finished. The lines are released on the edge that ends it, and the ready flag is not raised.
- R8: A transfer still running at a frame boundary blocks that boundary's capture. It also keeps the ready flag low through clocks 1021 to 1024 of that frame. The next capture happens at the following boundary, so a transfer in the deferred frame resends the old word.
- R9: The shifted word is the value captured at the last capture. Changes on `din` between captures have no effect on the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| din | input | WORD_W | Conversion word from the converter |
| rdy_n | output | 1 | Ready flag, low while a fresh word is held |
| sclk | output | 1 | Generated serial clock (low when not driven) |
| sclk_oe | output | 1 | Output enable for `sclk` |
| sdata | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Output enable for `sdata` |

## Verification
Every result is due at a known cycle counted from the edge on which the ready flag falls, which is cycle 1 of a frame:
- A transfer's enables rise on the checking edge itself.
- The serial clock rises two edges after each bit starts.
- The lines drop and the ready flag rises 4·WORD_W edges after the start.
- An early abort ends on the fourth edge of the bit in which chip select was seen high.

The bench locks to the first ready-flag fall and then counts edges. It drives inputs and samples outputs on the falling master clock just after the numbered edge, so every check lands on the exact cycle a register is due to change. A scoreboard queue holds the words the bench expects to see in order. A monitor rebuilds each word from the rising serial clock edges and compares it when the enables drop.

// File: rtl/sport_pkg.sv
// Shared types for the self-clocked serial output port.
package sport_pkg;

    // Frame-position strobes decoded from the frame counter.
    // Each strobe is high during the cycle before the edge it acts on.
    typedef struct packed {
        logic wrap;      // next edge starts a new frame
        logic poll;      // next edge is a chip-select check
        logic rdy_rise;  // next edge is where an idle frame raises the ready flag
    } frame_evt_t;

endpackage

// File: rtl/sport_frame_timer.sv
// Frame timer: counts master clocks through one frame and decodes the
// boundary, the chip-select check instants and the ready-flag rise point.
// Assumes FIRST_POLL >= 2 and that every check instant lies inside the frame.
// The counter resets to the last count, so the first edge after reset wraps.
module sport_frame_timer
    import sport_pkg::*;
#(
    parameter int FRAME_LEN  = 1024,
    parameter int READY_HIGH = 4,
    parameter int FIRST_POLL = 76,
    parameter int POLL_GAP   = 128,
    parameter int NUM_POLLS  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    output frame_evt_t evt
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] RISE_CNT = CW'(FRAME_LEN - READY_HIGH - 1);

    logic [CW-1:0]        fc;
    logic [NUM_POLLS-1:0] hit;

    // Position counter, wrapping once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)              fc <= LAST_CNT;
        else if (fc == LAST_CNT) fc <= '0;
        else                     fc <= fc + 1'b1;
    end

    // One comparator per check instant. The edge numbered c is reached
    // when the counter holds c-2.
    for (genvar k = 0; k < NUM_POLLS; k++) begin : g_poll
        assign hit[k] = (fc == CW'(FIRST_POLL - 2 + k * POLL_GAP));
    end

    // Strobe decode.
    always_comb begin
        evt.wrap     = (fc == LAST_CNT);
        evt.poll     = |hit;
        evt.rdy_rise = (fc == RISE_CNT);
    end

    a_r3_single_check: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    a_r3_check_off_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.poll && evt.wrap));
    a_r2_rise_then_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        evt.rdy_rise |=> !evt.wrap);

endmodule

// File: rtl/sport_cs_qual.sv
// Chip-select qualifier: tracks how many consecutive edges have sampled
// cs_n low, and reports whether the current edge would meet the setup rule.
// Assumes cs_n is already synchronous to clk.
module sport_cs_qual #(
    parameter int CS_SETUP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_ok
);
    localparam int SW = $clog2(CS_SETUP + 1);
    localparam logic [SW-1:0] RUN_MAX = SW'(CS_SETUP);

    logic [SW-1:0] low_run;

    // Saturating count of consecutive low samples, cleared by any high sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_run <= '0;
        else if (cs_n)             low_run <= '0;
        else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
    end

    // Low now and low for the required number of earlier edges.
    assign cs_ok = !cs_n && (low_run == RUN_MAX);

    a_r4_prior_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ok |-> !$past(cs_n));

endmodule

// File: rtl/sport_shifter.sv
// Serial shifter: loads a word on start, makes a serial clock at
// clk/SCLK_DIV (low half first) and shifts MSB first. The next bit appears
// on the edge where the serial clock falls. It stops after the last bit, or
// at the end of any bit during which cs_n was sampled high.
// Assumes SCLK_DIV is even and at least 2.
module sport_shifter #(
    parameter int WORD_W   = 16,
    parameter int SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cs_n,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              sclk,
    output logic              sdata,
    output logic              done_full
);
    localparam int BW = $clog2(WORD_W);
    localparam int PW = $clog2(SCLK_DIV);
    localparam logic [PW-1:0] PH_LAST = PW'(SCLK_DIV - 1);
    localparam logic [PW-1:0] PH_HIGH = PW'(SCLK_DIV / 2);

    logic [PW-1:0]     ph;
    logic [BW-1:0]     left;
    logic [WORD_W-1:0] shreg;
    logic              quit;
    logic              bit_end;
    logic              stop_now;

    // Bit-end and stop decode.
    always_comb begin
        bit_end   = busy && (ph == PH_LAST);
        done_full = bit_end && (left == '0);
        stop_now  = bit_end && ((left == '0) || quit || cs_n);
    end

    // Transfer sequencing: phase, bit count, shift and early-stop request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            ph    <= '0;
            left  <= '0;
            shreg <= '0;
            quit  <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            ph    <= '0;
            left  <= BW'(WORD_W - 1);
            shreg <= word;
            quit  <= 1'b0;
        end else if (busy) begin
            if (bit_end) begin
                ph <= '0;
                if (stop_now) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {shreg[WORD_W-2:0], 1'b0};
                    left  <= left - 1'b1;
                end
            end else begin
                ph <= ph + 1'b1;
                if (cs_n) quit <= 1'b1;
            end
        end
    end

    // Serial line values.
    assign sclk  = busy && (ph >= PH_HIGH);
    assign sdata = shreg[WORD_W-1];

    a_r5_data_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata));
    a_r6_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_full |=> !busy && !sclk);
    a_r7_quit_ends_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && quit) |=> !busy);

endmodule

// File: rtl/sport_ssc_tx.sv
// Self-clocked serial output port. It captures a word once per frame into a
// holding register, checks chip select at fixed instants and shifts the
// held word out on its own serial clock. The serial lines are released
// (enables low) when idle. A transfer running across a frame boundary
// defers that boundary's capture by one frame.
// Assumes cs_n and din are synchronous to clk.
module sport_ssc_tx
    import sport_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int FRAME_LEN  = 1024,
    parameter int READY_HIGH = 4,
    parameter int FIRST_POLL = 76,
    parameter int POLL_GAP   = 128,
    parameter int NUM_POLLS  = 8,
    parameter int CS_SETUP   = 3,
    parameter int SCLK_DIV   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [WORD_W-1:0] din,
    output logic              rdy_n,
    output logic              sclk,
    output logic              sclk_oe,
    output logic              sdata,
    output logic              sdata_oe
);
    frame_evt_t        evt;
    logic              cs_ok;
    logic              busy;
    logic              done_full;
    logic              start;
    logic [WORD_W-1:0] hold;

    sport_frame_timer #(
        .FRAME_LEN (FRAME_LEN),
        .READY_HIGH(READY_HIGH),
        .FIRST_POLL(FIRST_POLL),
        .POLL_GAP  (POLL_GAP),
        .NUM_POLLS (NUM_POLLS)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt)
    );

    sport_cs_qual #(
        .CS_SETUP(CS_SETUP)
    ) u_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .cs_n (cs_n),
        .cs_ok(cs_ok)
    );

    // A check instant with a qualified chip select starts a transfer when idle.
    assign start = evt.poll && cs_ok && !busy;

    sport_shifter #(
        .WORD_W  (WORD_W),
        .SCLK_DIV(SCLK_DIV)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cs_n     (cs_n),
        .word     (hold),
        .busy     (busy),
        .sclk     (sclk),
        .sdata    (sdata),
        .done_full(done_full)
    );

    // Capture at an idle boundary, and ready-flag control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
            hold  <= '0;
        end else if (evt.wrap && !busy) begin
            rdy_n <= 1'b0;
            hold  <= din;
        end else if (done_full || (evt.rdy_rise && !busy)) begin
            rdy_n <= 1'b1;
        end
    end

    assign sclk_oe  = busy;
    assign sdata_oe = busy;

    a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold));
    a_r2_fall_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(evt.wrap));
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $past(done_full || (evt.rdy_rise && !busy)));
    a_r8_no_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.wrap && busy) |=> !$fell(rdy_n));

endmodule

// File: tb/tb_sport_ssc_tx.sv
`timescale 1ns/1ps
module tb_sport_ssc_tx;
    localparam int W = 16;
    localparam logic [W-1:0] WA = 16'hA5C3;
    localparam logic [W-1:0] WB = 16'h1F80;
    localparam logic [W-1:0] WC = 16'h7E01;
    localparam logic [W-1:0] WD = 16'hC3B4;
    localparam logic [W-1:0] WE = 16'h0F5A;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cs_n;
    logic [W-1:0] din;
    logic         rdy_n, sclk, sclk_oe, sdata, sdata_oe;

    int n_chk = 0;
    int n_err = 0;
    int cur   = 0;
    bit done  = 0;

    logic [W-1:0] expq[$];
    logic [W-1:0] sh     = '0;
    int           nb     = 0;
    int           part_n = -1;
    logic [W-1:0] part_v = '0;

    always #2.5 clk = ~clk;

    sport_ssc_tx dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
        .rdy_n(rdy_n), .sclk(sclk), .sclk_oe(sclk_oe),
        .sdata(sdata), .sdata_oe(sdata_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard.
    task automatic expect_word(input logic [W-1:0] w);
        expq.push_back(w);
    endtask

    // Advance to just after edge n (cycle 1 = edge of the first ready fall).
    task automatic at_cycle(input int n);
        repeat (n - cur) @(posedge clk);
        cur = n;
        @(negedge clk);
    endtask

    // Monitor: rebuild words from rising serial clock edges.
    always @(posedge sclk) begin
        if (sdata_oe) begin
            sh = {sh[W-2:0], sdata};
            nb++;
        end
    end

    // Compare when the port releases the lines.
    always @(negedge sdata_oe) begin
        if (nb == W) begin
            if (expq.size() == 0) check("R5 unexpected word", {16'h0, sh}, 32'hFFFF_FFFF);
            else check("R5 serial word", {16'h0, sh}, {16'h0, expq.pop_front()});
        end else begin
            part_n = nb;
            part_v = sh;
        end
        nb = 0;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cs_n  = 1'b1;
        din   = WA;
        repeat (4) @(negedge clk);
        check("R1 rdy_n in reset", rdy_n, 1);
        check("R1 sdata_oe in reset", sdata_oe, 0);
        check("R1 sclk_oe in reset", sclk_oe, 0);
        check("R1 sclk in reset", sclk, 0);
        rst_n = 1'b1;
        @(negedge rdy_n);
        @(negedge clk);
        cur = 1;
        check("R1 frame starts after reset", rdy_n, 0);

        // Frame 0: window 1 with exactly 3 earlier low samples.
        at_cycle(72);  cs_n = 1'b0; expect_word(WA);
        at_cycle(75);  check("R4 no start before check", sdata_oe, 0);
        at_cycle(76);  check("R4 exact setup accepted", sdata_oe, 1);
                       check("R5 sclk low at start", sclk, 0);
                       check("R5 MSB first", sdata, WA[15]);
        at_cycle(78);  check("R5 sclk high half", sclk, 1);
        at_cycle(80);  check("R5 sclk falls", sclk, 0);
                       check("R5 second bit", sdata, WA[14]);
        at_cycle(139); check("R6 still sending", sdata_oe, 1);
                       check("R6 ready still low", rdy_n, 0);
        at_cycle(140); check("R6 data released", sdata_oe, 0);
                       check("R6 clock released", sclk_oe, 0);
                       check("R6 ready rises", rdy_n, 1);
        at_cycle(150); check("R6 stays released with cs low", sdata_oe, 0);
        cs_n = 1'b1;
        din  = WB;
        at_cycle(1024); check("R2 ready high before boundary", rdy_n, 1);
        at_cycle(1025); check("R2 ready falls at boundary", rdy_n, 0);

        // Frame 1: short setup skipped, then window 3 with a stale din change.
        at_cycle(1097); cs_n = 1'b0;
        at_cycle(1101); check("R4 short setup skipped", sdata_oe, 0);
        at_cycle(1110); check("R3 low cs between checks ignored", sdata_oe, 0);
        cs_n = 1'b1;
        at_cycle(1200); din = WC;
        at_cycle(1340); cs_n = 1'b0; expect_word(WB);
        at_cycle(1355); check("R3 no start before third check", sdata_oe, 0);
        at_cycle(1356); check("R3 third check starts", sdata_oe, 1);
        at_cycle(1420); check("R6 release after 4*W", sdata_oe, 0);
        at_cycle(1425); cs_n = 1'b1;

        // Frame 2: early abort, then idle ready timing.
        at_cycle(2110); cs_n = 1'b0;
        at_cycle(2133); cs_n = 1'b1;
        at_cycle(2135); check("R7 current bit completes", sdata_oe, 1);
        at_cycle(2136); check("R7 released at bit end", sdata_oe, 0);
                        check("R7 sclk low at release", sclk, 0);
                        check("R7 ready not raised", rdy_n, 0);
                        check("R7 bits sent", part_n, 3);
                        check("R7 partial bits", {29'h0, part_v[2:0]}, {29'h0, WC[15:13]});
        at_cycle(2500); din = WD;
        at_cycle(3068); check("R2 ready low through 1020", rdy_n, 0);
        at_cycle(3069); check("R2 ready high at 1021", rdy_n, 1);
        at_cycle(3072); check("R2 ready high at 1024", rdy_n, 1);
        at_cycle(3073); check("R2 next frame falls", rdy_n, 0);

        // Frame 3: eighth window crosses the boundary.
        at_cycle(4030); cs_n = 1'b0; expect_word(WD);
        at_cycle(4044); check("R8 eighth check starts", sdata_oe, 1);
        at_cycle(4050); din = WE;
        at_cycle(4093); check("R8 ready held low while busy", rdy_n, 0);
        at_cycle(4097); check("R8 no fall-capture at boundary", rdy_n, 0);
                        check("R8 transfer continues", sdata_oe, 1);
        at_cycle(4107); check("R8 last bit", sdata_oe, 1);
        at_cycle(4108); check("R8 release", sdata_oe, 0);
                        check("R8 ready rises on completion", rdy_n, 1);
        at_cycle(4110); cs_n = 1'b1;

        // Frame 4: deferred frame resends the old word.
        at_cycle(4280); cs_n = 1'b0; expect_word(WD);
        at_cycle(4300); check("R9 resend starts", sdata_oe, 1);
        at_cycle(4370); cs_n = 1'b1;
        at_cycle(5120); check("R8 ready high before late capture", rdy_n, 1);
        at_cycle(5121); check("R8 late capture", rdy_n, 0);

        // Frame 5: new word finally sent.
        at_cycle(5180); cs_n = 1'b0; expect_word(WE);
        at_cycle(5260); check("R8 new word sent", sdata_oe, 0);
        cs_n = 1'b1;
        at_cycle(5270); check("R5 all expected words seen", expq.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule